// File: doc/BRIEF.md
# Rolling Four-Activate Window Gate

This block sits beside a DRAM command scheduler and answers one question on every controller clock: may an ACTIVATE go out to this rank now? Within any rolling window only four row openings are permitted. A fifth must wait until the window that began with the oldest of the last four has run out. The scheduler reads `act_ok`. It pulses `act_issue` in the cycle it really sends an ACTIVATE.

The window length in clock cycles depends on two things. The first is the page size, which follows from the device data width. The second is the speed grade, which sets a nanosecond minimum. The block converts that minimum to cycles using a configured clock period in picoseconds, rounding up. It then takes the larger of that figure and a fixed cycle floor for the page size. Configuration is captured only while the synchronous reset is held. Reset also clears the issue history.

A free-running cycle counter stamps every accepted ACTIVATE into a four-entry ring. A per-entry sticky "aged out" flag keeps a long idle period from reading as a recent issue when the counter wraps.

Top module: `act_window_gate`

## Requirements
- R1: In the first cycle after the synchronous active-low reset is released, `act_ok` is 1 and `act_violation` is 0.
- R2: The first four ACTIVATEs after reset may be issued on four consecutive cycles. `act_ok` stays 1 for each of them.
- R3: If four ACTIVATEs were issued and the oldest of them was issued in cycle t0, `act_ok` is 0 up to cycle t0+W-1 and returns to 1 in cycle t0+W, where W is the window length in cycles.
- R4: W is the larger of a cycle floor and ceil(ns_min*1000 / tck_ps). The floor is 16 for `page_sel`=0 (x4, half-KB page), 20 for `page_sel`=1 (x8, 1 KB page), and 28 for `page_sel`=2 or 3 (x16, 2 KB page).
- R5: ns_min for `speed_sel` codes 0,1,2,3 (1600, 1866, 2133, 2400 MT/s) is 20,17,15,13 ns for the half-KB page, 25,23,21,21 ns for the 1 KB page, and 35,30,30,30 ns for the 2 KB page.
- R6: When `act_issue` is 1 while `act_ok` is 0, `act_violation` is 1 in that same cycle, and the history is left unchanged, so the next grant cycle does not move.
- R7: Changes to `page_sel`, `speed_sel` and `tck_ps` while reset is released have no effect until the next reset.
- R8: The window slides. After a fifth ACTIVATE, each further grant is timed from the second, third and so on most recent-but-three issue.
- R9: An idle period longer than the stamp counter's range does not block again: `act_ok` remains 1 at every cycle once the window has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| page_sel | input | 2 | Page size code: 0 half KB, 1 one KB, 2 or 3 two KB |
| speed_sel | input | 2 | Speed grade code: 0 1600, 1 1866, 2 2133, 3 2400 |
| tck_ps | input | TCK_W | Clock period in picoseconds |
| act_issue | input | 1 | High in a cycle when an ACTIVATE is sent |
| act_ok | output | 1 | An ACTIVATE may be sent this cycle |
| act_violation | output | 1 | An ACTIVATE was sent while not allowed |

## Verification
The bench measures the first granted cycle after a maximum-rate burst for every width and speed pairing. It also covers extra clock periods where the nanosecond term, rather than the floor, wins. A design that rounds down, or takes the floor alone, grants one or more cycles early. A design that is off by one in its age compare grants a cycle late or early. The bench issues an illegal ACTIVATE mid-window: a design that records it pushes the grant later. It also checks that the sliding order holds and that a block returns at the fifth slot after a dense run. Inputs are changed without a reset to catch a design that recomputes the window live. An idle stretch past the counter range exposes a design that compares wrapped stamps without remembering that the window had already expired.

// File: rtl/faw_pkg.sv
// Shared constants and lookup functions for the four-activate window gate.
// Assumes page codes 2 and 3 both mean the 2 KB page.
package faw_pkg;

    localparam int ACT_LIMIT_DEF = 4;

    // Cycle floor of the window for a page size code.
    function automatic logic [7:0] floor_cycles(input logic [1:0] pg);
        case (pg)
            2'd0:    floor_cycles = 8'd16;
            2'd1:    floor_cycles = 8'd20;
            default: floor_cycles = 8'd28;
        endcase
    endfunction

    // Nanosecond minimum of the window for page size and speed grade codes.
    function automatic logic [7:0] min_ns(input logic [1:0] pg, input logic [1:0] sp);
        logic [7:0] r;
        case (pg)
            2'd0: begin
                case (sp)
                    2'd0: r = 8'd20;
                    2'd1: r = 8'd17;
                    2'd2: r = 8'd15;
                    default: r = 8'd13;
                endcase
            end
            2'd1: begin
                case (sp)
                    2'd0: r = 8'd25;
                    2'd1: r = 8'd23;
                    default: r = 8'd21;
                endcase
            end
            default: begin
                r = (sp == 2'd0) ? 8'd35 : 8'd30;
            end
        endcase
        min_ns = r;
    endfunction

endpackage

// File: rtl/faw_window_calc.sv
// Converts page size, speed grade and clock period into a window length in cycles.
// Pure combinational; result is max(floor, ceil(ns*1000/tck)), clamped to WIN_W bits.
// Assumes tck_ps of zero is treated as one picosecond.
module faw_window_calc #(
    parameter int TCK_W = 16,
    parameter int WIN_W = 8
) (
    input  logic [1:0]       pg,
    input  logic [1:0]       sp,
    input  logic [TCK_W-1:0] tck_ps,
    output logic [WIN_W-1:0] win
);
    import faw_pkg::*;

    localparam logic [31:0] WIN_MAX = 32'((64'd1 << WIN_W) - 64'd1);

    logic [31:0] ps_min;
    logic [31:0] den;
    logic [31:0] ns_cyc;
    logic [31:0] fl_cyc;
    logic [31:0] pick;

    // Round the nanosecond minimum up to whole cycles and keep the larger term.
    always_comb begin
        ps_min = 32'(min_ns(pg, sp)) * 32'd1000;
        den    = (tck_ps == '0) ? 32'd1 : 32'(tck_ps);
        ns_cyc = (ps_min + den - 32'd1) / den;
        fl_cyc = 32'(floor_cycles(pg));
        pick   = (ns_cyc > fl_cyc) ? ns_cyc : fl_cyc;
        win    = (pick > WIN_MAX) ? WIN_MAX[WIN_W-1:0] : pick[WIN_W-1:0];
    end

endmodule

// File: rtl/faw_stamp_ring.sv
// Ring of the most recent DEPTH issue stamps with a sticky aged-out flag per slot.
// The flag sets once a slot's age reaches the window, so counter wrap during a long
// idle cannot make an old stamp look recent. Assumes win < 2**CNT_W.
module faw_stamp_ring #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] now,
    input  logic [CNT_W-1:0] win,
    input  logic             push,
    output logic             full,
    output logic             oldest_expired
);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  stamp_q [DEPTH];
    logic [DEPTH-1:0]  aged_q;
    logic [DEPTH-1:0]  hit;
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [FILL_W-1:0] fill_q;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            logic [CNT_W-1:0] age;
            // Age of this slot against the current window.
            always_comb begin
                age     = now - stamp_q[gi];
                hit[gi] = (age >= win);
            end
            // Store the stamp on push to this slot; otherwise latch aged-out.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stamp_q[gi] <= '0;
                    aged_q[gi]  <= 1'b0;
                end else if (push && (wr_ptr_q == PTR_W'(gi))) begin
                    stamp_q[gi] <= now;
                    aged_q[gi]  <= 1'b0;
                end else begin
                    aged_q[gi]  <= aged_q[gi] | hit[gi];
                end
            end
        end
    endgenerate

    // Advance the write pointer and the saturating fill count on each push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            fill_q   <= '0;
        end else if (push) begin
            wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (fill_q != FILL_W'(DEPTH)) fill_q <= fill_q + 1'b1;
        end
    end

    // The slot under the write pointer holds the oldest stamp once full.
    always_comb begin
        full           = (fill_q == FILL_W'(DEPTH));
        oldest_expired = aged_q[wr_ptr_q] | hit[wr_ptr_q];
    end

endmodule

// File: rtl/act_window_gate.sv
// Top of the four-activate window gate for one rank.
// Captures configuration while rst_n is low, derives the window length, keeps
// the issue history and raises act_ok when one more ACTIVATE is legal.
// Assumes the computed window fits in CNT_W bits (clamped otherwise).
module act_window_gate #(
    parameter int TCK_W     = 16,
    parameter int CNT_W     = 8,
    parameter int ACT_LIMIT = faw_pkg::ACT_LIMIT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       page_sel,
    input  logic [1:0]       speed_sel,
    input  logic [TCK_W-1:0] tck_ps,
    input  logic             act_issue,
    output logic             act_ok,
    output logic             act_violation
);
    logic [1:0]       cfg_pg_q;
    logic [1:0]       cfg_sp_q;
    logic [TCK_W-1:0] cfg_tck_q;
    logic [CNT_W-1:0] now_q;
    logic [CNT_W-1:0] win;
    logic             full;
    logic             oldest_expired;
    logic             push;

    // Capture configuration only while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_pg_q  <= page_sel;
            cfg_sp_q  <= speed_sel;
            cfg_tck_q <= tck_ps;
        end
    end

    // Free-running cycle counter used as the issue stamp.
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + 1'b1;
    end

    faw_window_calc #(.TCK_W(TCK_W), .WIN_W(CNT_W)) u_calc (
        .pg     (cfg_pg_q),
        .sp     (cfg_sp_q),
        .tck_ps (cfg_tck_q),
        .win    (win)
    );

    faw_stamp_ring #(.DEPTH(ACT_LIMIT), .CNT_W(CNT_W)) u_ring (
        .clk            (clk),
        .rst_n          (rst_n),
        .now            (now_q),
        .win            (win),
        .push           (push),
        .full           (full),
        .oldest_expired (oldest_expired)
    );

    // Grant decision and misuse flag; only legal issues enter the history.
    always_comb begin
        act_ok        = !full || oldest_expired;
        act_violation = act_issue && !act_ok;
        push          = act_issue && act_ok;
    end

endmodule

// File: rtl/act_window_gate_chk.sv
// Property checker for act_window_gate, attached by bind. Observes ports only.
module act_window_gate_chk #(
    parameter int ACT_LIMIT = 4
) (
    input logic clk,
    input logic rst_n,
    input logic act_issue,
    input logic act_ok,
    input logic act_violation
);
    localparam int N_W = $clog2(ACT_LIMIT + 1);

    logic [N_W-1:0] granted_q;

    // Count accepted ACTIVATEs since reset, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) granted_q <= '0;
        else if (act_issue && act_ok && granted_q != N_W'(ACT_LIMIT))
            granted_q <= granted_q + 1'b1;
    end

    p_reset_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (act_ok && !act_violation));

    p_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({act_ok, act_violation}));

    p_first_four_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (granted_q < N_W'(ACT_LIMIT)) |-> act_ok);

    p_drop_after_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_ok) |-> $past(act_issue));

    p_viol_when_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_violation |-> (!act_ok && act_issue));

endmodule

bind act_window_gate act_window_gate_chk #(.ACT_LIMIT(ACT_LIMIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .act_issue     (act_issue),
    .act_ok        (act_ok),
    .act_violation (act_violation)
);

// File: tb/test_act_window_gate.sv
module test_act_window_gate;

    typedef struct packed {
        logic [1:0]  pg;
        logic [1:0]  sp;
        logic [15:0] tck;
        logic [7:0]  w;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 16'd1250, 8'd16},
        '{2'd0, 2'd1, 16'd1072, 8'd16},
        '{2'd0, 2'd2, 16'd938,  8'd16},
        '{2'd0, 2'd3, 16'd833,  8'd16},
        '{2'd1, 2'd0, 16'd1250, 8'd20},
        '{2'd1, 2'd1, 16'd1072, 8'd22},
        '{2'd1, 2'd2, 16'd938,  8'd23},
        '{2'd1, 2'd3, 16'd833,  8'd26},
        '{2'd2, 2'd0, 16'd1250, 8'd28},
        '{2'd2, 2'd1, 16'd1072, 8'd28},
        '{2'd2, 2'd2, 16'd938,  8'd32},
        '{2'd2, 2'd3, 16'd833,  8'd37},
        '{2'd0, 2'd0, 16'd625,  8'd32},
        '{2'd3, 2'd1, 16'd1072, 8'd28},
        '{2'd2, 2'd0, 16'd1000, 8'd35}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  page_sel = 2'd0;
    logic [1:0]  speed_sel = 2'd0;
    logic [15:0] tck_ps = 16'd1250;
    logic        act_issue = 1'b0;
    logic        act_ok;
    logic        act_violation;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    act_window_gate i_act_window_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .page_sel      (page_sel),
        .speed_sel     (speed_sel),
        .tck_ps        (tck_ps),
        .act_issue     (act_issue),
        .act_ok        (act_ok),
        .act_violation (act_violation)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] pg, input logic [1:0] sp, input logic [15:0] tck);
        act_issue = 1'b0;
        page_sel  = pg;
        speed_sel = sp;
        tck_ps    = tck;
        rst_n     = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // Four back-to-back issues; returns cycle offset of the first grant after them.
    task automatic burst(input string tag, output int k);
        for (int i = 0; i < 4; i++) begin
            check(act_ok === 1'b1, {"R2 ", tag}, int'(act_ok), 1);
            act_issue = 1'b1;
            step();
        end
        act_issue = 1'b0;
        k = 4;
        while (act_ok !== 1'b1 && k < 200) begin
            step();
            k++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int k;
        // R1: reset state
        do_reset(2'd0, 2'd0, 16'd1250);
        check(act_ok === 1'b1, "R1 ok after reset", int'(act_ok), 1);
        check(act_violation === 1'b0, "R1 no violation after reset", int'(act_violation), 0);

        // Table walk: R3, R4, R5 grant cycle and R8 sliding order
        for (int v = 0; v < NV; v++) begin
            do_reset(VECS[v].pg, VECS[v].sp, VECS[v].tck);
            burst($sformatf("row %0d", v), k);
            check(k == int'(VECS[v].w), $sformatf("R3 R4 R5 grant row %0d", v), k, int'(VECS[v].w));
            for (int j = 0; j < 4; j++) begin
                check(act_ok === 1'b1, $sformatf("R8 slide row %0d step %0d", v, j), int'(act_ok), 1);
                act_issue = 1'b1;
                step();
            end
            act_issue = 1'b0;
            check(act_ok === 1'b0, $sformatf("R8 reblock row %0d", v), int'(act_ok), 0);
        end

        // R6: illegal issue flagged and not recorded
        do_reset(2'd0, 2'd0, 16'd1250);
        for (int i = 0; i < 4; i++) begin
            act_issue = 1'b1;
            step();
        end
        #1;
        check(act_violation === 1'b1, "R6 flag on blocked issue", int'(act_violation), 1);
        step();
        act_issue = 1'b0;
        #1;
        check(act_violation === 1'b0, "R6 flag clears", int'(act_violation), 0);
        k = 5;
        while (act_ok !== 1'b1 && k < 200) begin
            step();
            k++;
        end
        check(k == 16, "R6 grant unchanged", k, 16);

        // R7: config change without reset is ignored, then applied after reset
        do_reset(2'd0, 2'd0, 16'd1250);
        page_sel  = 2'd2;
        speed_sel = 2'd3;
        tck_ps    = 16'd833;
        burst("R7 live change", k);
        check(k == 16, "R7 window unchanged before reset", k, 16);
        do_reset(2'd2, 2'd3, 16'd833);
        burst("R7 after reset", k);
        check(k == 37, "R7 window applied after reset", k, 37);

        // R9: idle past counter range keeps act_ok high
        do_reset(2'd0, 2'd0, 16'd1250);
        burst("R9", k);
        begin
            int lows = 0;
            for (int i = 0; i < 300; i++) begin
                if (act_ok !== 1'b1) lows++;
                step();
            end
            check(lows == 0, "R9 cycles blocked during idle", lows, 0);
        end
        for (int i = 0; i < 4; i++) begin
            check(act_ok === 1'b1, "R9 burst after idle", int'(act_ok), 1);
            act_issue = 1'b1;
            step();
        end
        act_issue = 1'b0;
        check(act_ok === 1'b0, "R9 block after new burst", int'(act_ok), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule